// File: doc/BRIEF.md
# Bus Access Abort Decoder

This block sits beside a processor's bus interface and judges every access against a fixed memory map. For each valid access it classifies the address into a region and decides, from the region and the kind of access, whether the access must be refused. A refused instruction fetch raises a prefetch-abort flag. A refused data read or write raises a data-abort flag. Both flags, a region code and a register offset are registered, so the verdict appears on the cycle after the access is presented.

The rules depend on the access kind as well as the address. Peripheral space and the special-register window are open to data accesses but closed to instruction fetches. Flash can be read and executed, but a direct write to it is refused. Gaps between memories, and peripheral slots that no peripheral occupies, refuse every access. Inside an occupied peripheral slot only the low offset bits are decoded. An undefined offset therefore lands on one of that peripheral's registers instead of aborting. Every window, size and slot-occupancy mask is an elaboration-time parameter.

Top module: `bus_abort_check`

## Requirements
- R1: An access to an address that matches no implemented window reports region code 7. A fetch there raises the prefetch abort and a data access raises the data abort. Implemented windows by default: flash 0x00000000–0x0007FFFF, special 0x3FFF8000–0x3FFFFFFF, SRAM 0x40000000–0x4000FFFF, boot ROM 0x7FFFE000–0x7FFFFFFF, external 0x80000000–0xBFFFFFFF, APB 0xE0000000–0xE01FFFFF, AHB 0xFFE00000–0xFFFFFFFF.
- R2: A fetch from an occupied AHB or APB slot raises the prefetch abort. A read or write to the same address raises no abort.
- R3: A fetch inside the special window 0x3FFF8000–0x3FFFFFFF raises the prefetch abort. Data reads and writes there raise no abort.
- R4: Both peripheral windows are split into 16 KB slots, with slot index = (address − window base) / 16384. A set bit in the window's occupancy mask marks an occupied slot. By default APB slots 0–4, 6–10 and 31 are occupied, and AHB slots 0–4. An access to a vacant slot is treated as R1: region code 7, with an abort of the matching kind.
- R5: A data access to an occupied APB slot reports region code 5 and register offset = address bits [11:0], with no abort. For example, 0xE000D000 (slot 3) gives offset 0x000, the same offset as 0xE000C000.
- R6: A data write to flash raises the data abort. A flash read or fetch raises none.
- R7: The flags, region code and offset change one clock after a valid access. A cycle with the valid strobe low gives both flags low on the next cycle, and the region code and offset keep their previous values.
- R8: Access kind encoding: 2'b00 fetch, 2'b01 read, 2'b10 write, 2'b11 also write. The prefetch abort is raised only for fetches, the data abort only for reads and writes, and never both together.
- R9: Region codes: 0 flash, 1 SRAM, 2 special, 3 boot ROM, 4 AHB, 5 APB, 6 external, 7 none. SRAM, boot ROM and external memory accept every access kind. The offset output is zero for every region except APB.
- R10: While reset is active, and after it until the first valid access, both flags are low, the region code is 7 and the offset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | AW (32) | Access byte address |
| acc_kind | input | 2 | 00 fetch, 01 read, 10/11 write |
| pabort | output | 1 | Prefetch abort, registered |
| dabort | output | 1 | Data abort, registered |
| region | output | 3 | Region code of the last valid access |
| reg_offset | output | OFF_W (12) | Register offset within an APB slot |

## Verification
The bench targets the edges of every window. These include the last flash word next to the first gap byte, both ends of the special window, and the first byte past SRAM. A comparator that is off by one would put the wrong region on those addresses and drop or invent an abort. The bench also drives a vacant APB slot between two occupied ones, and the aliasing address one page above an occupied slot's base. A decoder that used too many offset bits would report a wrong offset there, and one that ignored the mask would accept the vacant slot. Fetch and data accesses are sent to the same peripheral and special addresses, and the 2'b11 kind is sent to flash. A wrong kind rule would then swap or merge the two flags. Idle cycles placed between accesses expose flags or region codes that fail to hold or clear.

// File: rtl/abort_map_pkg.sv
package abort_map_pkg;

   typedef enum logic [2:0] {
      RGN_FLASH   = 3'd0,
      RGN_SRAM    = 3'd1,
      RGN_SPECIAL = 3'd2,
      RGN_BOOT    = 3'd3,
      RGN_AHB     = 3'd4,
      RGN_APB     = 3'd5,
      RGN_EXT     = 3'd6,
      RGN_NONE    = 3'd7
   } region_e;

   localparam logic [1:0] KIND_FETCH = 2'b00;

   typedef struct packed {
      logic pab;
      logic dab;
   } verdict_t;

   function automatic logic kind_is_fetch(input logic [1:0] kind);
      return kind == KIND_FETCH;
   endfunction

   function automatic logic kind_is_write(input logic [1:0] kind);
      return kind[1];
   endfunction

endpackage

// File: rtl/window_match.sv
module window_match #(
   parameter int            AW   = 32,
   parameter logic [AW-1:0] BASE = '0,
   parameter longint        SIZE = 64'h1000
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   localparam logic [AW:0] LO = {1'b0, BASE};
   localparam logic [AW:0] HI = LO + (AW+1)'(SIZE);

   initial begin
      assert (SIZE > 0) else $error("window_match: empty window");
      assert ((SIZE & (SIZE - 1)) == 0) else $error("window_match: size not a power of two");
      assert (HI <= (1 << AW)) else $error("window_match: window wraps the address space");
   end

   always_comb begin
      hit = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
   end
endmodule

// File: rtl/periph_slots.sv
module periph_slots #(
   parameter int               AW         = 32,
   parameter logic [AW-1:0]    BASE       = '0,
   parameter int               SLOTS      = 128,
   parameter int               SLOT_BYTES = 16384,
   parameter int               OFF_W      = 12,
   parameter logic [SLOTS-1:0] MASK       = '1
) (
   input  logic [AW-1:0]    addr,
   output logic             in_window,
   output logic             occupied,
   output logic [OFF_W-1:0] offset
);
   localparam int     SLOT_LG = $clog2(SLOT_BYTES);
   localparam int     IDX_W   = $clog2(SLOTS);
   localparam longint SPAN    = longint'(SLOTS) * longint'(SLOT_BYTES);

   initial begin
      assert (SLOTS >= 2 && (SLOTS & (SLOTS - 1)) == 0) else $error("periph_slots: slot count");
      assert ((SLOT_BYTES & (SLOT_BYTES - 1)) == 0) else $error("periph_slots: slot size");
      assert (OFF_W <= SLOT_LG) else $error("periph_slots: offset wider than a slot");
      assert ((BASE & AW'(SPAN - 1)) == '0) else $error("periph_slots: base not aligned");
   end

   logic [IDX_W-1:0] slot_idx;

   window_match #(.AW(AW), .BASE(BASE), .SIZE(SPAN)) u_win (
      .addr (addr),
      .hit  (in_window)
   );

   always_comb begin
      slot_idx = IDX_W'((addr - BASE) >> SLOT_LG);
      occupied = in_window && MASK[slot_idx];
      offset   = addr[OFF_W-1:0];
   end
endmodule

// File: rtl/region_classify.sv
module region_classify import abort_map_pkg::*; #(
   parameter int                   AW          = 32,
   parameter int                   OFF_W       = 12,
   parameter logic [AW-1:0]        FLASH_BASE  = 32'h0000_0000,
   parameter longint               FLASH_SIZE  = 64'h0008_0000,
   parameter logic [AW-1:0]        SPEC_BASE   = 32'h3FFF_8000,
   parameter longint               SPEC_SIZE   = 64'h0000_8000,
   parameter logic [AW-1:0]        SRAM_BASE   = 32'h4000_0000,
   parameter longint               SRAM_SIZE   = 64'h0001_0000,
   parameter logic [AW-1:0]        BOOT_BASE   = 32'h7FFF_E000,
   parameter longint               BOOT_SIZE   = 64'h0000_2000,
   parameter bit                   EXT_EN      = 1'b1,
   parameter logic [AW-1:0]        EXT_BASE    = 32'h8000_0000,
   parameter longint               EXT_SIZE    = 64'h4000_0000,
   parameter int                   SLOT_BYTES  = 16384,
   parameter logic [AW-1:0]        APB_BASE    = 32'hE000_0000,
   parameter int                   APB_SLOTS   = 128,
   parameter logic [APB_SLOTS-1:0] APB_MASK    = '1,
   parameter logic [AW-1:0]        AHB_BASE    = 32'hFFE0_0000,
   parameter int                   AHB_SLOTS   = 128,
   parameter logic [AHB_SLOTS-1:0] AHB_MASK    = '1,
   parameter bit                   AHB_OFFSETS = 1'b0
) (
   input  logic [AW-1:0]    addr,
   output region_e          region,
   output logic [OFF_W-1:0] offset
);
   logic hit_flash, hit_spec, hit_sram, hit_boot, hit_ext;
   logic apb_win, apb_occ, ahb_win, ahb_occ;
   logic [OFF_W-1:0] apb_off, ahb_off;

   window_match #(.AW(AW), .BASE(FLASH_BASE), .SIZE(FLASH_SIZE)) u_flash (.addr(addr), .hit(hit_flash));
   window_match #(.AW(AW), .BASE(SPEC_BASE),  .SIZE(SPEC_SIZE))  u_spec  (.addr(addr), .hit(hit_spec));
   window_match #(.AW(AW), .BASE(SRAM_BASE),  .SIZE(SRAM_SIZE))  u_sram  (.addr(addr), .hit(hit_sram));
   window_match #(.AW(AW), .BASE(BOOT_BASE),  .SIZE(BOOT_SIZE))  u_boot  (.addr(addr), .hit(hit_boot));

   generate
      if (EXT_EN) begin : g_ext
         window_match #(.AW(AW), .BASE(EXT_BASE), .SIZE(EXT_SIZE)) u_ext (.addr(addr), .hit(hit_ext));
      end else begin : g_no_ext
         assign hit_ext = 1'b0;
      end
   endgenerate

   periph_slots #(
      .AW(AW), .BASE(APB_BASE), .SLOTS(APB_SLOTS), .SLOT_BYTES(SLOT_BYTES),
      .OFF_W(OFF_W), .MASK(APB_MASK)
   ) u_apb (
      .addr      (addr),
      .in_window (apb_win),
      .occupied  (apb_occ),
      .offset    (apb_off)
   );

   periph_slots #(
      .AW(AW), .BASE(AHB_BASE), .SLOTS(AHB_SLOTS), .SLOT_BYTES(SLOT_BYTES),
      .OFF_W(OFF_W), .MASK(AHB_MASK)
   ) u_ahb (
      .addr      (addr),
      .in_window (ahb_win),
      .occupied  (ahb_occ),
      .offset    (ahb_off)
   );

   always_comb begin
      region = RGN_NONE;
      offset = '0;
      if (hit_spec)                region = RGN_SPECIAL;
      else if (hit_flash)          region = RGN_FLASH;
      else if (hit_sram)           region = RGN_SRAM;
      else if (hit_boot)           region = RGN_BOOT;
      else if (apb_win) begin
         if (apb_occ) begin
            region = RGN_APB;
            offset = apb_off;
         end
      end else if (ahb_win) begin
         if (ahb_occ) begin
            region = RGN_AHB;
            if (AHB_OFFSETS) offset = ahb_off;
         end
      end else if (hit_ext)        region = RGN_EXT;
   end
endmodule

// File: rtl/abort_policy.sv
module abort_policy import abort_map_pkg::*; (
   input  logic       valid,
   input  logic [1:0] kind,
   input  region_e    region,
   output verdict_t   verdict
);
   logic fetch, write, fetch_bad, data_bad;

   always_comb begin
      fetch     = kind_is_fetch(kind);
      write     = kind_is_write(kind);
      fetch_bad = 1'b0;
      data_bad  = 1'b0;
      unique case (region)
         RGN_NONE: begin
            fetch_bad = 1'b1;
            data_bad  = 1'b1;
         end
         RGN_AHB, RGN_APB, RGN_SPECIAL: fetch_bad = 1'b1;
         RGN_FLASH:                     data_bad  = write;
         default: ;
      endcase
      verdict.pab = valid &&  fetch && fetch_bad;
      verdict.dab = valid && !fetch && data_bad;
   end
endmodule

// File: rtl/bus_abort_check.sv
module bus_abort_check import abort_map_pkg::*; #(
   parameter int                   AW          = 32,
   parameter int                   OFF_W       = 12,
   parameter int                   SLOT_BYTES  = 16384,
   parameter int                   APB_SLOTS   = 128,
   parameter int                   AHB_SLOTS   = 128,
   parameter logic [APB_SLOTS-1:0] APB_MASK    = APB_SLOTS'(128'h8000_07DF),
   parameter logic [AHB_SLOTS-1:0] AHB_MASK    = AHB_SLOTS'(128'h1F),
   parameter bit                   EXT_EN      = 1'b1,
   parameter bit                   AHB_OFFSETS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [AW-1:0]    acc_addr,
   input  logic [1:0]       acc_kind,
   output logic             pabort,
   output logic             dabort,
   output logic [2:0]       region,
   output logic [OFF_W-1:0] reg_offset
);
   initial begin
      assert (AW == 32) else $error("bus_abort_check: default map needs a 32-bit address");
      assert (OFF_W >= 1) else $error("bus_abort_check: offset width");
   end

   region_e          rgn_d;
   logic [OFF_W-1:0] off_d;
   verdict_t         vd;

   region_classify #(
      .AW(AW), .OFF_W(OFF_W), .SLOT_BYTES(SLOT_BYTES), .EXT_EN(EXT_EN),
      .APB_SLOTS(APB_SLOTS), .APB_MASK(APB_MASK),
      .AHB_SLOTS(AHB_SLOTS), .AHB_MASK(AHB_MASK), .AHB_OFFSETS(AHB_OFFSETS)
   ) u_cls (
      .addr   (acc_addr),
      .region (rgn_d),
      .offset (off_d)
   );

   abort_policy u_pol (
      .valid   (acc_valid),
      .kind    (acc_kind),
      .region  (rgn_d),
      .verdict (vd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pabort     <= 1'b0;
         dabort     <= 1'b0;
         region     <= RGN_NONE;
         reg_offset <= '0;
      end else begin
         pabort <= vd.pab;
         dabort <= vd.dab;
         if (acc_valid) begin
            region     <= rgn_d;
            reg_offset <= off_d;
         end
      end
   end

   // checker-only: marks that the previous edge was outside reset
   logic live_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(pabort && dabort));
   assert_pabort_on_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pabort |-> $past(acc_kind) == KIND_FETCH);
   assert_dabort_on_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dabort |-> $past(acc_kind) != KIND_FETCH);
   assert_idle_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!pabort && !dabort));
   assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> ($stable(region) && $stable(reg_offset)));
   assert_unmapped_aborts_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(acc_valid) && region == RGN_NONE) |-> (pabort || dabort));
   assert_flash_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(acc_valid) && $past(acc_kind[1]) && region == RGN_FLASH) |-> dabort);
   assert_offset_apb_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (region != RGN_APB && !AHB_OFFSETS) |-> reg_offset == '0);
endmodule

// File: tb/sim_bus_abort_check.sv
`timescale 1ns/1ps
module sim_bus_abort_check;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_kind = '0;
   logic        pabort, dabort;
   logic [2:0]  region;
   logic [11:0] reg_offset;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic        e_p = 0, e_d = 0;
   logic [2:0]  e_r = 3'd7;
   logic [11:0] e_o = '0;
   string       e_tag = "R10";

   localparam logic [127:0] APB_OCC = 128'h8000_07DF;
   localparam logic [127:0] AHB_OCC = 128'h1F;

   always #2.5 clk = ~clk;

   bus_abort_check u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_kind(acc_kind), .pabort(pabort), .dabort(dabort),
      .region(region), .reg_offset(reg_offset)
   );

   function automatic void model(input logic [31:0] a, input logic [1:0] k,
                                 output logic p, output logic d,
                                 output logic [2:0] r, output logic [11:0] o);
      longint ua = longint'(a);
      int slot;
      bit fetch = (k == 2'b00);
      bit wr = (k >= 2'd2);
      o = '0;
      if (ua >= 64'h3FFF_8000 && ua < 64'h4000_0000) r = 3'd2;
      else if (ua < 64'h8_0000) r = 3'd0;
      else if (ua >= 64'h4000_0000 && ua < 64'h4001_0000) r = 3'd1;
      else if (ua >= 64'h7FFF_E000 && ua < 64'h8000_0000) r = 3'd3;
      else if (ua >= 64'hE000_0000 && ua < 64'hE020_0000) begin
         slot = int'((ua - 64'hE000_0000) / 16384);
         if (APB_OCC[slot]) begin r = 3'd5; o = a[11:0]; end
         else r = 3'd7;
      end else if (ua >= 64'hFFE0_0000) begin
         slot = int'((ua - 64'hFFE0_0000) / 16384);
         r = AHB_OCC[slot] ? 3'd4 : 3'd7;
      end else if (ua >= 64'h8000_0000 && ua < 64'hC000_0000) r = 3'd6;
      else r = 3'd7;
      p = fetch && (r == 3'd7 || r == 3'd4 || r == 3'd5 || r == 3'd2);
      d = !fetch && (r == 3'd7 || (r == 3'd0 && wr));
   endfunction

   task automatic compare();
      n_chk++;
      if (pabort !== e_p || dabort !== e_d || region !== e_r || reg_offset !== e_o) begin
         n_bad++;
         $display("FAIL %s: got pab=%b dab=%b rgn=%0d off=%h, expected pab=%b dab=%b rgn=%0d off=%h",
                  e_tag, pabort, dabort, region, reg_offset, e_p, e_d, e_r, e_o);
      end
   endtask

   // one cycle: check the verdict of the previous cycle, then present a new access
   task automatic step(input bit v, input logic [31:0] a, input logic [1:0] k, input string tag);
      logic p, d;
      logic [2:0] r;
      logic [11:0] o;
      @(negedge clk);
      compare();
      acc_valid = v; acc_addr = a; acc_kind = k;
      if (v) begin
         model(a, k, p, d, r, o);
         e_p = p; e_d = d; e_r = r; e_o = o;
      end else begin
         e_p = 0; e_d = 0;
      end
      e_tag = tag;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: got running, expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      e_tag = "R10";
      compare();                                   // R10 during reset
      rst_n = 1'b1;
      step(0, 32'h0, 2'b00, "R10");                // R10 after reset, idle
      step(1, 32'h0000_0100, 2'b00, "R6");         // flash fetch ok
      step(1, 32'h0000_0100, 2'b01, "R6");         // flash read ok
      step(1, 32'h0007_FFFC, 2'b10, "R6");         // flash write aborts
      step(1, 32'h0000_0040, 2'b11, "R8");         // kind 11 is a write
      step(1, 32'h0008_0000, 2'b00, "R1");         // gap after flash, fetch
      step(1, 32'h0008_0000, 2'b01, "R1");         // gap, read
      step(1, 32'h3FFF_8000, 2'b00, "R3");         // special fetch
      step(1, 32'h3FFF_FFFC, 2'b01, "R3");         // special read ok
      step(1, 32'h3FFF_8010, 2'b10, "R3");         // special write ok
      step(1, 32'h3FFF_7FFC, 2'b01, "R1");         // just below special
      step(1, 32'h4000_0010, 2'b00, "R9");         // sram fetch
      step(1, 32'h4000_FFFC, 2'b10, "R9");         // sram write
      step(1, 32'h4001_0000, 2'b01, "R1");         // past sram
      step(1, 32'h7FFF_E004, 2'b00, "R9");         // boot fetch
      step(1, 32'h8000_1000, 2'b10, "R9");         // external write
      step(1, 32'hC000_0000, 2'b01, "R1");         // beyond external
      step(1, 32'hE000_C004, 2'b00, "R2");         // APB fetch aborts
      step(1, 32'hE000_C004, 2'b01, "R2");         // APB read ok, offset 004
      step(1, 32'hE000_D000, 2'b01, "R5");         // alias to offset 000
      step(1, 32'hE000_EABC, 2'b10, "R5");         // offset ABC
      step(1, 32'hE001_4000, 2'b01, "R4");         // vacant APB slot 5
      step(1, 32'hE00A_0000, 2'b00, "R4");         // vacant APB slot 40
      step(1, 32'hE007_C008, 2'b01, "R5");         // occupied slot 31
      step(1, 32'hFFE0_4000, 2'b00, "R2");         // AHB fetch aborts
      step(1, 32'hFFE0_4000, 2'b10, "R2");         // AHB write ok
      step(1, 32'hFFE2_8000, 2'b01, "R4");         // vacant AHB slot 10
      step(1, 32'hE000_C123, 2'b01, "R7");
      step(0, 32'h0008_0000, 2'b00, "R7");         // idle: flags low, hold
      step(0, 32'hFFFF_FFFF, 2'b10, "R7");
      step(1, 32'h0008_0000, 2'b00, "R7");
      for (int i = 0; i < 600; i++) begin
         logic [31:0] a;
         a = $urandom;
         if (i % 3 == 0) a = {8'hE0, 3'b000, a[20:0]};
         else if (i % 5 == 0) a = {11'h7FF, 3'b111, a[17:0]} | 32'hFFE0_0000;
         step(($urandom % 4) != 0, a, 2'($urandom), "R8");
      end
      @(negedge clk);
      compare();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule